// File: doc/BRIEF.md
# Byte/Word ALU Status Flag Generator

This block turns the operands and result of an 8-bit or 16-bit arithmetic or logical operation into the status flags a processor keeps after each instruction: carry, parity, half-carry (auxiliary carry), zero, sign and overflow. The datapath adder lives outside. It hands this block the two operands, the result it produced, a three-bit operation class and a byte/word select. The block derives every flag from those values at the sign bit and the nibble boundary, so it never repeats the addition.

The flags are held in a register and packed into a 16-bit flag word at fixed bit positions. The same positions apply in both widths. Three control flags share that word: single-step trap, interrupt enable and string direction. Each one changes only through its own set and clear strobes. An update strobe decides whether the arithmetic flags take new values on a given clock edge. The word reflects the update one cycle after the strobe.

Top module: `alu_flag_gen`

## Requirements
- R1: A synchronous active-low reset clears the whole flag word to 0x0000 at the next rising clock edge.
- R2: The flag word places carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R3: Operation class codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow. For these classes carry is set on a carry out of the top bit of the selected width for add classes, and on a borrow into the top bit for subtract classes.
- R4: Parity is set when bits 7:0 of the result hold an even number of ones, in both byte and word mode.
- R5: Auxiliary carry is set on a carry out of bit 3 (add classes) or a borrow into bit 3 (subtract classes).
- R6: With word_i = 0 (byte mode) only bits 7:0 of the operands and result count. Zero is set when the result in the selected width is all zeros, and sign copies bit 7 in byte mode or bit 15 in word mode.
- R7: Overflow is set when the signed result does not fit the selected width: the operands have equal signs and the result has the other sign (add), or the operands have different signs and the result's sign differs from the first operand's (subtract).
- R8: Class 4 (increment) and class 5 (decrement) treat the second operand as 1 and ignore op_b_i. They update parity, auxiliary carry, zero, sign and overflow, and carry keeps its previous value.
- R9: Classes 6 and 7 (logical) clear carry, overflow and auxiliary carry, and compute zero, sign and parity from the result.
- R10: The arithmetic flags change only on a clock edge where upd_en_i is 1, and the new values are visible from that edge on. With upd_en_i at 0 they hold.
- R11: Control strobes use bit 0 for trap, bit 1 for interrupt enable and bit 2 for direction. A set strobe makes the flag 1 at the next edge and a clear strobe makes it 0. Clear wins when both are given. The control flags do not depend on upd_en_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en_i | input | 1 | Load the arithmetic flags on this edge |
| op_i | input | 3 | Operation class code |
| word_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| op_a_i | input | 16 | First operand as given to the adder |
| op_b_i | input | 16 | Second operand as given to the adder |
| result_i | input | 16 | Result produced by the external datapath |
| ctl_set_i | input | 3 | Set strobes for trap, interrupt enable, direction |
| ctl_clr_i | input | 3 | Clear strobes for trap, interrupt enable, direction |
| flags_o | output | 16 | Packed flag word |

## Verification
The flag word is a register, so a wrong internal flag shows at the ports one cycle after the edge that loaded it. It then stays visible until the next update or reset. A wrong carry that is held through an increment or decrement persists across several operations. For that reason, increments and decrements are placed after operations that leave carry both set and clear. Byte-mode vectors carry nonzero upper bytes, so a width select taken from the wrong bits changes zero, sign or carry at once. Control-flag strobes are issued while upd_en_i is low, which shows any coupling between the two register groups in the same cycle.

// File: rtl/alu_flag_pkg.sv
// Shared definitions for the ALU status flag generator.
// Assumes a 16-bit packed flag word with fixed positions for both widths.
package alu_flag_pkg;

    localparam int FLAG_W = 16;
    localparam int CTL_N  = 3;

    // Bit positions inside the packed flag word (decoded by neighbours).
    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    // Control strobe bit order.
    localparam int CTL_TRAP = 0;
    localparam int CTL_INTR = 1;
    localparam int CTL_DIR  = 2;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_ADC   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_SBB   = 3'd3,
        OPC_INC   = 3'd4,
        OPC_DEC   = 3'd5,
        OPC_LOGIC = 3'd6,
        OPC_LOGX  = 3'd7
    } flag_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } stat_flags_t;

endpackage

// File: rtl/alu_flag_parity.sv
// Even-parity detector over a parameterised slice.
// Assumes the caller passes only the bits that take part in parity.
module alu_flag_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         even_o
);
    // Flag is 1 when the number of ones in the slice is even.
    always_comb begin
        even_o = ~(^bits_i);
    end
endmodule

// File: rtl/alu_flag_calc.sv
// Combinational status flag derivation from operands and result.
// Assumes result_i is what the external adder produced for op_i; carry,
// borrow and overflow are recovered from the sign bits and bit 4 alone.
module alu_flag_calc
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [2:0]        op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] result_i,
    output stat_flags_t       flags_o,
    output logic              keep_cry_o
);
    localparam int NVAR = 2;

    flag_op_e          opc;
    logic              is_sub;
    logic              is_step;
    logic              is_logic;
    logic [DATA_W-1:0] b_eff;
    logic [NVAR-1:0]   v_cry;
    logic [NVAR-1:0]   v_ovf;
    logic [NVAR-1:0]   v_zro;
    logic [NVAR-1:0]   v_sgn;
    logic              aux_raw;
    logic              par_raw;

    // Decode the operation class into the few properties the flags need.
    always_comb begin
        opc      = flag_op_e'(op_i);
        is_sub   = (opc == OPC_SUB) || (opc == OPC_SBB) || (opc == OPC_DEC);
        is_step  = (opc == OPC_INC) || (opc == OPC_DEC);
        is_logic = (opc == OPC_LOGIC) || (opc == OPC_LOGX);
        b_eff    = is_step ? DATA_W'(1) : op_b_i;
    end

    // One flag slice per supported width; index 0 is byte, 1 is word.
    for (genvar g = 0; g < NVAR; g++) begin : g_width
        localparam int W = (g == 0) ? BYTE_W : DATA_W;
        logic am, bm, rm;

        // Sign-bit carry, borrow, overflow plus zero and sign per width.
        always_comb begin
            am = op_a_i[W-1];
            bm = b_eff[W-1];
            rm = result_i[W-1];
            if (is_sub) begin
                v_cry[g] = (~am & bm) | ((~am | bm) & rm);
                v_ovf[g] = (am != bm) && (rm != am);
            end else begin
                v_cry[g] = (am & bm) | ((am | bm) & ~rm);
                v_ovf[g] = (am == bm) && (rm != am);
            end
            v_zro[g] = (result_i[W-1:0] == '0);
            v_sgn[g] = rm;
        end
    end

    // Carry into bit 4 is the same for sums and differences.
    always_comb begin
        aux_raw = op_a_i[NIB_W] ^ b_eff[NIB_W] ^ result_i[NIB_W];
    end

    alu_flag_parity #(.W(BYTE_W)) u_par (
        .bits_i (result_i[BYTE_W-1:0]),
        .even_o (par_raw)
    );

    // Select the width and mask the flags that logical classes clear.
    always_comb begin
        flags_o.cry = is_logic ? 1'b0 : v_cry[word_i];
        flags_o.ovf = is_logic ? 1'b0 : v_ovf[word_i];
        flags_o.aux = is_logic ? 1'b0 : aux_raw;
        flags_o.zro = v_zro[word_i];
        flags_o.sgn = v_sgn[word_i];
        flags_o.par = par_raw;
        keep_cry_o  = is_step;
    end
endmodule

// File: rtl/alu_flag_ctrl.sv
// Control flag register bank (trap, interrupt enable, direction).
// Assumes one set and one clear strobe per flag; clear has priority.
module alu_flag_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] ctl_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        // Hold each control flag, clear first, then set.
        always_ff @(posedge clk) begin
            if (!rst_n)        ctl_o[k] <= 1'b0;
            else if (clr_i[k]) ctl_o[k] <= 1'b0;
            else if (set_i[k]) ctl_o[k] <= 1'b1;
        end
    end
endmodule

// File: rtl/alu_flag_gen.sv
// Top of the ALU status flag generator: computes status flags, stores them
// under an update strobe, and packs them with the control flags.
// Assumes the datapath delivers operands and result in the same cycle.
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en_i,
    input  logic [2:0]        op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [CTL_N-1:0]  ctl_set_i,
    input  logic [CTL_N-1:0]  ctl_clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    stat_flags_t      calc_flags;
    stat_flags_t      stat_q;
    logic             keep_cry;
    logic [CTL_N-1:0] ctl_q;

    alu_flag_calc #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .NIB_W  (NIB_W)
    ) u_calc (
        .op_i       (op_i),
        .word_i     (word_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .result_i   (result_i),
        .flags_o    (calc_flags),
        .keep_cry_o (keep_cry)
    );

    alu_flag_ctrl #(.N(CTL_N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ctl_set_i),
        .clr_i (ctl_clr_i),
        .ctl_o (ctl_q)
    );

    // Status register: load on update, carry held for increment/decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (upd_en_i) begin
            stat_q     <= calc_flags;
            stat_q.cry <= keep_cry ? stat_q.cry : calc_flags.cry;
        end
    end

    // Pack status and control flags at their fixed positions.
    always_comb begin
        flags_o         = '0;
        flags_o[POS_CF] = stat_q.cry;
        flags_o[POS_PF] = stat_q.par;
        flags_o[POS_AF] = stat_q.aux;
        flags_o[POS_ZF] = stat_q.zro;
        flags_o[POS_SF] = stat_q.sgn;
        flags_o[POS_OF] = stat_q.ovf;
        flags_o[POS_TF] = ctl_q[CTL_TRAP];
        flags_o[POS_IF] = ctl_q[CTL_INTR];
        flags_o[POS_DF] = ctl_q[CTL_DIR];
    end
endmodule

// Property checker for alu_flag_gen, attached through bind below.
// Assumes reset is held low across at least one clock edge at start-up.
module alu_flag_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en_i,
    input logic [2:0]  op_i,
    input logic        word_i,
    input logic [15:0] result_i,
    input logic [2:0]  ctl_set_i,
    input logic [2:0]  ctl_clr_i,
    input logic [15:0] flags_o
);
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[15:12] == 4'h0) && !flags_o[5] && !flags_o[3] && !flags_o[1]);

    a_r9_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && op_i[2] && op_i[1]) |=> (!flags_o[0] && !flags_o[4] && !flags_o[11]));

    a_r8_step_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && op_i[2] && !op_i[1]) |=> (flags_o[0] == $past(flags_o[0])));

    a_r10_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en_i |=> $stable({flags_o[11], flags_o[7:0]}));

    a_r6_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && word_i && result_i == 16'h0000) |=> flags_o[6]);

    a_r6_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !word_i) |=> (flags_o[7] == $past(result_i[7])));

    a_r11_trap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr_i[0] |=> !flags_o[8]);

    a_r11_trap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set_i[0] && !ctl_clr_i[0]) |=> flags_o[8]);
endmodule

bind alu_flag_gen alu_flag_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en_i  (upd_en_i),
    .op_i      (op_i),
    .word_i    (word_i),
    .result_i  (result_i),
    .ctl_set_i (ctl_set_i),
    .ctl_clr_i (ctl_clr_i),
    .flags_o   (flags_o)
);

// File: tb/alu_flag_gen_tb.sv
// Self-checking bench: a vector table walked in order, then directed
// tests for hold, control flags and reset.
module alu_flag_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        word_i = 1'b0;
    logic [15:0] op_a_i = '0;
    logic [15:0] op_b_i = '0;
    logic [15:0] result_i = '0;
    logic [2:0]  ctl_set_i = '0;
    logic [2:0]  ctl_clr_i = '0;
    logic [15:0] flags_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_flag_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en_i  (upd_en_i),
        .op_i      (op_i),
        .word_i    (word_i),
        .op_a_i    (op_a_i),
        .op_b_i    (op_b_i),
        .result_i  (result_i),
        .ctl_set_i (ctl_set_i),
        .ctl_clr_i (ctl_clr_i),
        .flags_o   (flags_o)
    );

    // Vector: {class, word, a, b, result, expected flag word}.
    // Flag values: CF 001, PF 004, AF 010, ZF 040, SF 080, OF 800.
    localparam int NV = 14;
    localparam logic [67:0] VEC [NV] = '{
        {3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 16'h0055}, // R3 R5 R6 R4 byte carry out
        {3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 16'h0890}, // R7 byte overflow
        {3'd0, 1'b1, 16'h8000, 16'h8000, 16'h0000, 16'h0845}, // R3 R7 word
        {3'd2, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095}, // R3 borrow word
        {3'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 16'h0810}, // R7 R5 byte sub
        {3'd1, 1'b1, 16'h1234, 16'h0FCB, 16'h2200, 16'h0014}, // R5 R4 add with carry
        {3'd3, 1'b0, 16'h0010, 16'h0010, 16'h00FF, 16'h0095}, // R3 sub with borrow
        {3'd4, 1'b0, 16'h00FF, 16'h005A, 16'h0000, 16'h0055}, // R8 inc, b ignored, CF kept 1
        {3'd5, 1'b1, 16'h8000, 16'h1234, 16'h7FFF, 16'h0815}, // R8 dec, CF kept 1
        {3'd6, 1'b1, 16'hF0F0, 16'h0F0F, 16'h8001, 16'h0080}, // R9 logical
        {3'd7, 1'b0, 16'h00FF, 16'h00FF, 16'h0003, 16'h0004}, // R9 class 7
        {3'd0, 1'b0, 16'h12FF, 16'h3401, 16'h4600, 16'h0055}, // R6 byte ignores upper bits
        {3'd0, 1'b1, 16'h0001, 16'h0001, 16'h0002, 16'h0000}, // R3 R4 plain word add
        {3'd4, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0054}  // R8 inc keeps CF 0
    };

    task automatic check(input string req, input logic [15:0] exp);
        n_cmp++;
        if (flags_o !== exp) begin
            n_bad++;
            $display("FAIL %s: flags actual %04h expected %04h", req, flags_o, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 16'h0000);
        rst_n = 1'b1;

        // Table walk: one update per vector, checked after the loading edge (R10 latency, R2 layout).
        for (int i = 0; i < NV; i++) begin
            op_i     = VEC[i][67:65];
            word_i   = VEC[i][64];
            op_a_i   = VEC[i][63:48];
            op_b_i   = VEC[i][47:32];
            result_i = VEC[i][31:16];
            upd_en_i = 1'b1;
            step();
            check($sformatf("R2 vector %0d", i), VEC[i][15:0]);
        end

        // R10: no update strobe, inputs that would give a different word.
        upd_en_i = 1'b0;
        op_i = 3'd0; word_i = 1'b1;
        op_a_i = 16'h7FFF; op_b_i = 16'h0001; result_i = 16'h8000;
        step();
        check("R10 hold without update", 16'h0054);

        // R11: control flags change while status is held.
        ctl_set_i = 3'b001;
        step();
        check("R11 set trap", 16'h0154);
        ctl_set_i = 3'b110;
        step();
        check("R11 set interrupt and direction", 16'h0754);
        ctl_set_i = 3'b001; ctl_clr_i = 3'b001;
        step();
        check("R11 clear wins over set", 16'h0654);
        ctl_set_i = 3'b000; ctl_clr_i = 3'b100;
        step();
        check("R11 clear direction", 16'h0254);
        ctl_clr_i = 3'b000;

        // R1: reset from a nonzero word.
        rst_n = 1'b0;
        step();
        check("R1 reset clears word", 16'h0000);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule